// File: doc/BRIEF.md
# Delayed Write-Back Operand Queue

This block keeps the most recent rows of results produced by the function units of a wide-issue core for a short window of cycles. Instructions that issue soon after their producer can then take the operand from this small queue instead of from a read port of the large register file. Each cycle, every valid write-back lane is stored into the row at the write pointer, and the pointer turns to the next row, so the newest row always replaces the oldest one. The caller writes the same results into the register file in the same cycle, so the register file never depends on the queue for its contents.

The location of each waiting operand is tracked by a small down-counter per operand slot, together with the index of the write-back lane that produced it. On wakeup the counter is loaded with the queue depth and the lane is recorded. After that the counter loses one every cycle. A nonzero counter selects the queue row directly, relative to the write pointer, so no tag search is done. A zero counter sends the read to the register file. When a branch misprediction or an exception is signalled, every entry is invalidated and every counter is cleared at the same clock edge.

Each issue read port gets back the operand value, a flag that says it came from the queue, and a register-file read enable that is raised only when the register file really has to be read.

Top module: `wb_operand_queue`

## Requirements
- R1: After a synchronous active-low reset every counter is zero. Every requested read then goes to the register file: `rd_hit` is 0, `rf_rd_en` is 1 and `rd_data` equals `rf_rdata` for that port.
- R2: In each cycle that is not a flush, each lane with `wb_vld` set is stored into the row at the write pointer. The pointer advances by one row every cycle and wraps after DEPTH rows, so the oldest row is overwritten.
- R3: A wakeup of operand slot s in cycle t loads the counter of s with DEPTH (2) and records `wk_lane` for s, at the edge that ends cycle t. A later wakeup of the same slot reloads the counter and replaces the lane, whatever value the counter had.
- R4: Outside a wakeup or a flush, a nonzero counter decreases by one every cycle. A zero counter stays zero.
- R5: A read of a slot with counter 2 returns the result written in the previous cycle on the recorded lane. A read with counter 1 returns the result written two cycles earlier on that lane. In both cases `rd_hit` is 1 and `rf_rd_en` is 0.
- R6: A read of a slot with counter 0 returns `rf_rdata` with `rf_rd_en` set to 1 and `rd_hit` set to 0. So a result woken in cycle t is served by the queue in cycles t+1 and t+2, and by the register file from cycle t+3.
- R7: With `flush` high, at that edge all counters are cleared and all queue entries are invalidated. Writes and wakeups of the flush cycle are discarded. In the following cycle every requested read goes to the register file.
- R8: A port with `rd_req` at 0 drives `rd_hit` 0 and `rf_rd_en` 0, whatever slot it names.
- R9: All read ports work independently in the same cycle. Several ports may read the same slot or different rows, and each port gets its own correct value.
- R10: A slot woken on a lane whose `wb_vld` bit was 0 in the wakeup cycle does not hit in the queue. Its reads go to the register file.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Misprediction or exception flush; invalidates everything at the edge |
| wb_vld | input | LANES | Per-lane write-back valid for this cycle |
| wb_data | input | LANES*DW | Write-back results, lane l at bits [l*DW +: DW] |
| wk_vld | input | NOPS | Per-slot wakeup strobe, same cycle as the producing write-back |
| wk_lane | input | NOPS*LW | Producing lane for each waking slot, slot s at [s*LW +: LW] |
| rd_req | input | NRD | Per-port operand read request at issue |
| rd_slot | input | NRD*SW | Operand slot read by each port, port p at [p*SW +: SW] |
| rf_rdata | input | NRD*DW | Register-file read data for each port, same cycle |
| rf_rd_en | output | NRD | Register-file read enable per port |
| rd_data | output | NRD*DW | Delivered operand per port |
| rd_hit | output | NRD | Operand came from the queue |

## Verification
On every cycle, the assertions check the counter steps (load on wakeup, decrement, hold at zero, clear on flush), the capture of each valid lane into the row at the write pointer, the invalidation of all entries after a flush, and the quiet state of idle ports and of the register-file path for zero counters. Only the bench scenarios can show that the value delivered really is the result from the right cycle and lane. Examples are an operand read from the older row while a newer value for the same lane sits in the newest row, a reload that changes the lane, ports that share a slot, and long random sequences of bursts, wakeups and flushes compared against a shadow model of the operands.

// File: rtl/dwq_pkg.sv
// dwq_pkg: shared types and helpers for the delayed write-back operand queue.
// Assumes counters are loaded with the queue depth and never exceed it.
package dwq_pkg;

    // Where an issued operand is taken from.
    typedef enum logic {
        SRC_RF    = 1'b0,
        SRC_QUEUE = 1'b1
    } src_e;

    // Row holding a result whose counter reads cnt, given write pointer wp.
    // cnt == depth is the newest row (wp-1); cnt == 1 is the oldest row (wp).
    function automatic int unsigned row_for_count(int unsigned wp,
                                                  int unsigned cnt,
                                                  int unsigned depth);
        int unsigned sum;
        if (cnt == 0) begin
            sum = wp;
        end else begin
            sum = wp + cnt - 1;
            if (sum >= depth) sum = sum - depth;
        end
        return sum;
    endfunction

endpackage

// File: rtl/dwq_store.sv
// dwq_store: circular row storage. One row of LANES results is written per
// cycle at the write pointer, which advances every cycle and wraps at DEPTH.
// Each slot keeps a valid bit; a flush clears all valid bits and drops the
// write of that cycle. Data registers have no reset; only valids do.
module dwq_store #(
    parameter int LANES = 8,
    parameter int DEPTH = 2,
    parameter int DW    = 32,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  flush,
    input  logic [LANES-1:0]                      wb_vld,
    input  logic [LANES-1:0][DW-1:0]              wb_data,
    output logic [PW-1:0]                         wp,
    output logic [DEPTH-1:0][LANES-1:0][DW-1:0]   row_data,
    output logic [DEPTH-1:0][LANES-1:0]           row_vld
);

    // Write pointer: one step per cycle, wrapping after the last row.
    always_ff @(posedge clk) begin
        if (!rst_n)                     wp <= '0;
        else if (wp == PW'(DEPTH - 1))  wp <= '0;
        else                            wp <= wp + 1'b1;
    end

    for (genvar r = 0; r < DEPTH; r++) begin : g_row
        // Row valid bits: cleared by reset or flush, refreshed when written.
        always_ff @(posedge clk) begin
            if (!rst_n || flush)        row_vld[r] <= '0;
            else if (wp == PW'(r))      row_vld[r] <= wb_vld;
        end

        for (genvar l = 0; l < LANES; l++) begin : g_lane
            // Slot data: captured only for valid lanes of a normal cycle.
            always_ff @(posedge clk) begin
                if (!flush && wp == PW'(r) && wb_vld[l])
                    row_data[r][l] <= wb_data[l];
            end
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_chk
        a_r2_lane_captured: assert property (@(posedge clk) disable iff (!rst_n)
            (!flush && wb_vld[l]) |=>
                (row_data[$past(wp)][l] == $past(wb_data[l]) && row_vld[$past(wp)][l]))
            else $error("R2: valid lane not captured at write pointer");
    end

    a_r7_entries_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (row_vld == '0))
        else $error("R7: entries still valid after flush");

    a_r2_other_rows_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && DEPTH > 1) |=>
            (row_vld[(int'($past(wp)) + 1) % DEPTH] == $past(row_vld[(int'(wp) + 1) % DEPTH])))
        else $error("R2: row other than write pointer changed");

endmodule

// File: rtl/dwq_age_ctr.sv
// dwq_age_ctr: location tracker for one waiting operand. A wakeup loads the
// counter with DEPTH and records the producing lane; the counter then ages by
// one per cycle down to zero. A flush clears it and overrides a wakeup.
module dwq_age_ctr #(
    parameter int LANES = 8,
    parameter int DEPTH = 2,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int LW   = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          wk,
    input  logic [LW-1:0] wk_lane,
    output logic [CW-1:0] cnt,
    output logic [LW-1:0] lane
);

    // Counter: clear on reset/flush, load on wakeup, otherwise age to zero.
    always_ff @(posedge clk) begin
        if (!rst_n || flush)   cnt <= '0;
        else if (wk)           cnt <= CW'(DEPTH);
        else if (cnt != '0)    cnt <= cnt - 1'b1;
    end

    // Lane register: captured with each accepted wakeup.
    always_ff @(posedge clk) begin
        if (!rst_n)            lane <= '0;
        else if (wk && !flush) lane <= wk_lane;
    end

    a_r3_load_depth: assert property (@(posedge clk) disable iff (!rst_n)
        (wk && !flush) |=> (cnt == CW'(DEPTH) && lane == $past(wk_lane)))
        else $error("R3: wakeup did not load counter and lane");

    a_r4_age_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!wk && !flush && cnt != '0) |=> (cnt == $past(cnt) - 1'b1 && $stable(lane)))
        else $error("R4: counter did not age by one");

    a_r4_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!wk && cnt == '0) |=> (cnt == '0))
        else $error("R4: zero counter moved without wakeup");

    a_r7_ctr_flush: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (cnt == '0))
        else $error("R7: counter survived flush");

endmodule

// File: rtl/dwq_rd_sel.sv
// dwq_rd_sel: read steering for one issue port. The slot's counter and lane
// point straight at a queue slot; a nonzero counter on a valid slot is served
// by the queue, anything else by the register file. Purely combinational; clk
// and rst_n only qualify the checks.
module dwq_rd_sel #(
    parameter int LANES = 8,
    parameter int DEPTH = 2,
    parameter int DW    = 32,
    parameter int NOPS  = 16,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int LW   = (LANES > 1) ? $clog2(LANES) : 1,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int SW   = (NOPS > 1) ? $clog2(NOPS) : 1
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  req,
    input  logic [SW-1:0]                         slot,
    input  logic [CW-1:0]                         cnt_all [NOPS],
    input  logic [LW-1:0]                         lane_all [NOPS],
    input  logic [PW-1:0]                         wp,
    input  logic [DEPTH-1:0][LANES-1:0][DW-1:0]   row_data,
    input  logic [DEPTH-1:0][LANES-1:0]           row_vld,
    input  logic [DW-1:0]                         rf_rdata,
    output logic [DW-1:0]                         data,
    output logic                                  hit,
    output logic                                  rf_en
);
    import dwq_pkg::*;

    logic [CW-1:0] cnt;
    logic [LW-1:0] lane;
    logic [PW-1:0] row;
    src_e          src;

    // Locate the operand: pick the slot's tracker and turn its count into a row.
    always_comb begin
        cnt  = cnt_all[slot];
        lane = lane_all[slot];
        row  = PW'(row_for_count(32'(wp), 32'(cnt), DEPTH));
    end

    // Choose the source and drive the port outputs.
    always_comb begin
        src   = (req && cnt != '0 && row_vld[row][lane]) ? SRC_QUEUE : SRC_RF;
        hit   = (src == SRC_QUEUE);
        rf_en = req && (src == SRC_RF);
        data  = hit ? row_data[row][lane] : rf_rdata;
    end

    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req |-> (!hit && !rf_en))
        else $error("R8: idle port active");

    a_r6_zero_to_rf: assert property (@(posedge clk) disable iff (!rst_n)
        (req && cnt_all[slot] == '0) |-> (rf_en && !hit && data == rf_rdata))
        else $error("R6: zero counter not steered to register file");

endmodule

// File: rtl/wb_operand_queue.sv
// wb_operand_queue: delayed write-back operand queue. Keeps the last DEPTH
// rows of write-back results and serves issue reads from them while the
// per-slot down-counter is nonzero. Assumes the caller writes the same results
// to the register file in the same cycle and that wakeups arrive in the
// producer's write-back cycle.
module wb_operand_queue #(
    parameter int LANES = 8,
    parameter int DEPTH = 2,
    parameter int DW    = 32,
    parameter int NOPS  = 16,
    parameter int NRD   = 4,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int LW   = (LANES > 1) ? $clog2(LANES) : 1,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int SW   = (NOPS > 1) ? $clog2(NOPS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                flush,
    input  logic [LANES-1:0]    wb_vld,
    input  logic [LANES*DW-1:0] wb_data,
    input  logic [NOPS-1:0]     wk_vld,
    input  logic [NOPS*LW-1:0]  wk_lane,
    input  logic [NRD-1:0]      rd_req,
    input  logic [NRD*SW-1:0]   rd_slot,
    input  logic [NRD*DW-1:0]   rf_rdata,
    output logic [NRD-1:0]      rf_rd_en,
    output logic [NRD*DW-1:0]   rd_data,
    output logic [NRD-1:0]      rd_hit
);

    logic [LANES-1:0][DW-1:0]            wb_arr;
    logic [PW-1:0]                       wp;
    logic [DEPTH-1:0][LANES-1:0][DW-1:0] row_data;
    logic [DEPTH-1:0][LANES-1:0]         row_vld;
    logic [CW-1:0]                       cnt_all  [NOPS];
    logic [LW-1:0]                       lane_all [NOPS];

    // Reshape the flat write-back bus into lanes.
    assign wb_arr = wb_data;

    dwq_store #(.LANES(LANES), .DEPTH(DEPTH), .DW(DW)) i_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .wb_vld   (wb_vld),
        .wb_data  (wb_arr),
        .wp       (wp),
        .row_data (row_data),
        .row_vld  (row_vld)
    );

    for (genvar s = 0; s < NOPS; s++) begin : g_slot
        dwq_age_ctr #(.LANES(LANES), .DEPTH(DEPTH)) i_ctr (
            .clk     (clk),
            .rst_n   (rst_n),
            .flush   (flush),
            .wk      (wk_vld[s]),
            .wk_lane (wk_lane[s*LW +: LW]),
            .cnt     (cnt_all[s]),
            .lane    (lane_all[s])
        );
    end

    for (genvar p = 0; p < NRD; p++) begin : g_port
        dwq_rd_sel #(.LANES(LANES), .DEPTH(DEPTH), .DW(DW), .NOPS(NOPS)) i_sel (
            .clk      (clk),
            .rst_n    (rst_n),
            .req      (rd_req[p]),
            .slot     (rd_slot[p*SW +: SW]),
            .cnt_all  (cnt_all),
            .lane_all (lane_all),
            .wp       (wp),
            .row_data (row_data),
            .row_vld  (row_vld),
            .rf_rdata (rf_rdata[p*DW +: DW]),
            .data     (rd_data[p*DW +: DW]),
            .hit      (rd_hit[p]),
            .rf_en    (rf_rd_en[p])
        );
    end

    a_r7_no_hit_after_flush: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (rd_hit == '0))
        else $error("R7: queue hit in cycle after flush");

    a_r1_no_hit_after_reset: assert property (@(posedge clk)
        !rst_n |=> (rd_hit == '0))
        else $error("R1: queue hit right after reset");

endmodule

// File: tb/test_wb_operand_queue.sv
// Directed bench: one task per scenario, plus a random run against a shadow
// model of the operand slots (value, validity and remaining lifetime).
module test_wb_operand_queue;
    localparam int LANES = 8, DEPTH = 2, DW = 32, NOPS = 16, NRD = 4;
    localparam int LW = 3, SW = 4;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                flush = 1'b0;
    logic [LANES-1:0]    wb_vld = '0;
    logic [LANES*DW-1:0] wb_data = '0;
    logic [NOPS-1:0]     wk_vld = '0;
    logic [NOPS*LW-1:0]  wk_lane = '0;
    logic [NRD-1:0]      rd_req = '0;
    logic [NRD*SW-1:0]   rd_slot = '0;
    logic [NRD*DW-1:0]   rf_rdata = '0;
    logic [NRD-1:0]      rf_rd_en;
    logic [NRD*DW-1:0]   rd_data;
    logic [NRD-1:0]      rd_hit;

    always #5 clk = ~clk;

    wb_operand_queue #(.LANES(LANES), .DEPTH(DEPTH), .DW(DW), .NOPS(NOPS), .NRD(NRD))
        i_wb_operand_queue (.*);

    int n_chk = 0, n_bad = 0, cyc = 0;
    bit done = 0;

    // Shadow model of each operand slot.
    int            m_cnt [NOPS];
    logic          m_vld [NOPS];
    logic [DW-1:0] m_dat [NOPS];

    task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic put_wb(int l, logic [DW-1:0] d);
        wb_vld[l] = 1'b1;
        wb_data[l*DW +: DW] = d;
    endtask

    task automatic wake(int s, int l);
        wk_vld[s] = 1'b1;
        wk_lane[s*LW +: LW] = LW'(l);
    endtask

    task automatic rd(int p, int s);
        rd_req[p] = 1'b1;
        rd_slot[p*SW +: SW] = SW'(s);
    endtask

    // Compare every port against the shadow model after inputs settle.
    task automatic check_ports(string tag);
        #1;
        for (int p = 0; p < NRD; p++) begin
            int s;
            logic          eh, ee;
            logic [DW-1:0] ed;
            s  = int'(rd_slot[p*SW +: SW]);
            eh = rd_req[p] && m_cnt[s] > 0 && m_vld[s];
            ee = rd_req[p] && !eh;
            ed = eh ? m_dat[s] : rf_rdata[p*DW +: DW];
            chk($sformatf("%s port%0d hit", tag, p), DW'(rd_hit[p]), DW'(eh));
            chk($sformatf("%s port%0d rf_en", tag, p), DW'(rf_rd_en[p]), DW'(ee));
            if (rd_req[p]) chk($sformatf("%s port%0d data", tag, p), rd_data[p*DW +: DW], ed);
        end
    endtask

    // One clock edge: update the model from held inputs, then clear inputs.
    task automatic tick();
        @(posedge clk);
        if (!rst_n || flush) begin
            for (int s = 0; s < NOPS; s++) m_cnt[s] = 0;
        end else begin
            for (int s = 0; s < NOPS; s++) if (m_cnt[s] > 0) m_cnt[s]--;
            for (int s = 0; s < NOPS; s++) if (wk_vld[s]) begin
                int l;
                l = int'(wk_lane[s*LW +: LW]);
                m_cnt[s] = DEPTH;
                m_vld[s] = wb_vld[l];
                m_dat[s] = wb_data[l*DW +: DW];
            end
        end
        @(negedge clk);
        cyc++;
        wb_vld = '0; wk_vld = '0; flush = 1'b0; rd_req = '0;
        for (int p = 0; p < NRD; p++) rf_rdata[p*DW +: DW] = 32'hF000_0000 | (cyc << 4) | p;
    endtask

    task automatic t_reset();   // R1
        rst_n = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        for (int p = 0; p < NRD; p++) rd(p, p * 3);
        check_ports("R1 reset reads");
        chk("R1 all rf enables", DW'(rf_rd_en), DW'(4'hF));
        tick();
    endtask

    task automatic t_age();     // R3 R4 R5 R6
        put_wb(3, 32'hAAAA_0003);
        wake(5, 3);
        tick();
        rd(0, 5);
        check_ports("R5 newest row");
        chk("R5 newest value", rd_data[DW-1:0], 32'hAAAA_0003);
        put_wb(3, 32'hBBBB_0003);           // newer value on same lane
        tick();
        rd(0, 5);
        check_ports("R4 R5 older row");
        chk("R5 older value", rd_data[DW-1:0], 32'hAAAA_0003);
        tick();
        rd(0, 5);
        check_ports("R6 expired");
        chk("R6 rf used", DW'(rf_rd_en[0]), 32'd1);
        tick();
    endtask

    task automatic t_two_rows(); // R2 R9
        for (int l = 0; l < LANES; l++) put_wb(l, 32'hD000_0000 + l);
        wake(0, 2); wake(1, 7);
        tick();
        for (int l = 0; l < LANES; l++) put_wb(l, 32'hD100_0000 + l);
        wake(2, 2);
        rd(0, 0);
        check_ports("R2 first row");
        tick();
        for (int l = 0; l < LANES; l++) put_wb(l, 32'hD200_0000 + l);
        rd(0, 0); rd(1, 2); rd(2, 1); rd(3, 2);
        check_ports("R9 mixed rows");
        chk("R9 port1 newest", rd_data[DW +: DW], 32'hD100_0002);
        chk("R9 port2 older", rd_data[2*DW +: DW], 32'hD000_0007);
        tick();
        rd(0, 2); rd(1, 0);
        check_ports("R2 wrap overwrite");
        chk("R2 slot2 survives wrap", rd_data[DW-1:0], 32'hD100_0002);
        tick();
    endtask

    task automatic t_reload();  // R3
        put_wb(1, 32'h1111_0001);
        wake(4, 1);
        tick();
        put_wb(6, 32'h6666_0006);
        wake(4, 6);
        tick();
        rd(0, 4);
        check_ports("R3 reload");
        chk("R3 reload value", rd_data[DW-1:0], 32'h6666_0006);
        tick();
        rd(0, 4);
        check_ports("R3 reload aged");
        tick();
        rd(0, 4);
        check_ports("R3 reload expired");
        tick();
    endtask

    task automatic t_flush();   // R7
        put_wb(0, 32'hCAFE_0000);
        wake(6, 0);
        tick();
        flush = 1'b1;
        put_wb(4, 32'hCAFE_0004);
        wake(7, 4);
        rd(0, 6);
        check_ports("R7 before flush edge");
        tick();
        rd(0, 6); rd(1, 7);
        check_ports("R7 after flush");
        chk("R7 no hits", DW'(rd_hit), 32'd0);
        put_wb(4, 32'hBEEF_0004);
        wake(7, 4);
        tick();
        rd(0, 7);
        check_ports("R7 refill");
        chk("R7 refill value", rd_data[DW-1:0], 32'hBEEF_0004);
        tick();
    endtask

    task automatic t_idle();    // R8
        put_wb(2, 32'h2222_0002);
        wake(8, 2);
        tick();
        rd(0, 8);
        rd_slot[SW +: SW] = SW'(8);         // port 1 names the slot, no request
        check_ports("R8 idle port");
        chk("R8 idle hit", DW'(rd_hit[1]), 32'd0);
        chk("R8 idle rf_en", DW'(rf_rd_en[1]), 32'd0);
        tick();
    endtask

    task automatic t_invalid_lane(); // R10
        put_wb(5, 32'h5555_0005);
        tick();
        tick();                             // row with lane 5 valid is now the one rewritten
        wake(9, 5);                         // lane 5 not valid this cycle
        tick();
        rd(0, 9);
        check_ports("R10 invalid lane");
        chk("R10 rf used", DW'(rf_rd_en[0]), 32'd1);
        tick();
    endtask

    task automatic t_random();  // R9 and all others under random traffic
        for (int i = 0; i < 400; i++) begin
            wb_vld = LANES'($urandom);
            for (int l = 0; l < LANES; l++) wb_data[l*DW +: DW] = $urandom;
            for (int s = 0; s < NOPS; s++)
                if ($urandom_range(3) == 0) wake(s, $urandom_range(LANES - 1));
            for (int p = 0; p < NRD; p++)
                if ($urandom_range(4) != 0) rd(p, $urandom_range(NOPS - 1));
                else rd_slot[p*SW +: SW] = SW'($urandom_range(NOPS - 1));
            flush = ($urandom_range(19) == 0);
            check_ports("R9 random");
            tick();
        end
    endtask

    initial begin
        for (int s = 0; s < NOPS; s++) begin m_cnt[s] = 0; m_vld[s] = 0; m_dat[s] = '0; end
        t_reset();
        t_age();
        t_two_rows();
        t_reload();
        t_flush();
        t_idle();
        t_invalid_lane();
        t_random();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule